// File: doc/BRIEF.md
# Serial LED Driver Chain Loader

This block runs on the host side. It writes one display frame into a daisy chain of constant-current LED driver devices. Each device holds a 16-stage shift register and a bank of level-sensitive latches. A client hands over the whole chain's bit pattern, `NUM_DEV` times 16 bits wide, through a valid/ready handshake. The loader then shifts the bits out on a serial clock and data pair, and raises the latch-enable strobe once the last bit is in place. It reports completion with a one-cycle pulse.

All serial timing comes from the system clock. Four cycle counts set the timing: clock half-period, data setup, latch pulse width and latch spacing. These counts are sampled when a frame is accepted. Each count is raised to a floor derived from the system clock frequency, so the serial clock never runs faster than the chained or single-device limit. The same floors keep clock-high time, data setup and hold, and latch pulse and spacing at or above the devices' minimums.

A per-frame mode input selects the transparent-latch load. In that mode the latch enable stays high while the bits shift, and the blanking output is held active for the whole load. The LEDs therefore never show a partially shifted frame.

Top module: `led_chain_loader`

## Requirements
- R1: After reset, `frame_ready` is 1 and `drv_clk`, `drv_sdi`, `drv_le`, `drv_blank` and `load_done` are all 0.
- R2: A frame is taken on a cycle where `frame_valid` and `frame_ready` are both 1. `frame_ready` is 0 from the next cycle until `load_done` has pulsed. A `frame_valid` or `frame_data` change during a load has no effect on the loaded frame.
- R3: Exactly `NUM_DEV*16` rising edges of `drv_clk` occur per load. At rising edge k (k = 0 first), `drv_sdi` carries `frame_data[NUM_DEV*16-1-k]`. Bit `d*16+c` is channel c of device d, and device 0 is the one fed directly. After the load, device d's latches hold `frame_data[d*16 +: 16]`.
- R4: Every high phase of `drv_clk` lasts H = max(half count, MIN_HALF) cycles. MIN_HALF is the larger of half of ceil(f_sys/f_max) rounded up and ceil(16 ns·f_sys), where f_max is 25 MHz for a chain and 30 MHz for one device.
- R5: `drv_sdi` changes only at falling edges of `drv_clk` or when idle, and stays constant through each high phase. Each low phase before a rising edge lasts L = max(H, setup count, ceil(10 ns·f_sys)) cycles.
- R6 (normal mode): after the last falling edge, `drv_clk` stays low for G = max(spacing count, ceil(10 ns·f_sys)) cycles before `drv_le` rises. `drv_le` stays high for W = max(width count, ceil(20 ns·f_sys)) cycles. It is then low for G cycles before `load_done`. `drv_clk` is never high while `drv_le` is high.
- R7: `load_done` is high for exactly one cycle, K = NUM_DEV·16·(L+H) + 2G + W cycles after the accepting edge. `frame_ready` returns to 1 in the following cycle.
- R8 (transparent mode, `latch_bypass`=1 at accept): `drv_le` is high from the accepting edge for NUM_DEV·16·(L+H)+G+W cycles. `drv_blank` is high for K+1 cycles, covering every rising `drv_clk` edge, and that is never less than ceil(60 ns·f_sys).
- R9 (normal mode): `drv_blank` stays 0 throughout the load.
- R10: A count input of 0, or any value below its floor, behaves exactly like the floor value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Frame offered |
| frame_ready | output | 1 | Loader idle, frame can be taken |
| frame_data | input | NUM_DEV*16 | Chain bit pattern, bit d*16+c = device d channel c |
| latch_bypass | input | 1 | 1 selects transparent-latch load with blanking |
| cfg_half_cyc | input | CNT_W | Serial clock half-period in system cycles |
| cfg_setup_cyc | input | CNT_W | Minimum data setup before a rising edge |
| cfg_lew_cyc | input | CNT_W | Latch-enable pulse width |
| cfg_gap_cyc | input | CNT_W | Spacing between clock and latch enable |
| drv_clk | output | 1 | Serial shift clock to the chain |
| drv_sdi | output | 1 | Serial data to device 0 |
| drv_le | output | 1 | Latch enable, active high |
| drv_blank | output | 1 | Output blanking (drives active-low enable), 1 = LEDs off |
| load_done | output | 1 | One-cycle completion pulse |

## Verification
Every output is either a flop loaded from the next state or a decode of the current state. Each serial waveform edge therefore appears in the cycle right after the edge that changes state, and the accepting edge counts as cycle zero. The bench samples one time unit after each falling system-clock edge. It measures each phase of `drv_clk`, `drv_le` and `drv_blank` as a run length in cycles and compares it with L, H, G, W, or K+1, computed from the requirement formulas for the counts driven. `load_done` must be seen exactly K+1 samples after the sample that presented the frame. `frame_ready` must be high at the next sample. The latched words of a behavioural device chain are compared with the frame once the pulse has been seen.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_SHIFT_LO = 3'd1,
      ST_SHIFT_HI = 3'd2,
      ST_LE_SETUP = 3'd3,
      ST_LE_PULSE = 3'd4,
      ST_LE_HOLD  = 3'd5,
      ST_DONE     = 3'd6
   } ldr_state_t;

   // Ceiling of a/b for elaboration-time arithmetic.
   function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction

   // Nanoseconds to system-clock cycles, rounded up, never below 1.
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
      int unsigned c;
      c = cdiv(ns * mhz, 1000);
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ldr_floor.sv
// Raises one programmable cycle count to its floor; offers the live value
// and a copy captured when a frame is accepted.
module ldr_floor #(
   parameter int unsigned CW    = 8,
   parameter int unsigned FLOOR = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [CW-1:0] raw,
   output logic [CW-1:0] now,
   output logic [CW-1:0] held
);
   localparam logic [CW-1:0] FLOOR_V = CW'(FLOOR);

   if (FLOOR < 1 || FLOOR >= (1 << CW)) begin : g_bad_floor
      $error("ldr_floor: FLOOR %0d does not fit CW %0d", FLOOR, CW);
   end

   assign now = (raw < FLOOR_V) ? FLOOR_V : raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held <= FLOOR_V;
      else if (capture) held <= now;
   end

   assert_floor_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      held >= FLOOR_V);

endmodule

// File: rtl/ldr_timer.sv
// Phase timer: a state loaded with value V lasts exactly V cycles.
module ldr_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] start_val,
   output logic          expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= start_val - 1'b1;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   assert_start_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (start_val != '0));

endmodule

// File: rtl/ldr_shifter.sv
// Holds the accepted frame and presents the current serial bit, highest
// index first. STYLE 0 selects by index, STYLE 1 shifts the frame word.
module ldr_shifter #(
   parameter int unsigned TOTAL = 32,
   parameter int unsigned STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOTAL-1:0] frame,
   input  logic             shift,
   output logic             bit_out,
   output logic             last
);
   localparam int unsigned IW = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam logic [IW-1:0] TOP_IDX = IW'(TOTAL - 1);

   logic [IW-1:0]    idx_q;
   logic [TOTAL-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (load)  idx_q <= TOP_IDX;
      else if (shift) idx_q <= idx_q - 1'b1;
   end

   assign last = (idx_q == '0);

   if (STYLE == 0) begin : g_indexed
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    word_q <= '0;
         else if (load) word_q <= frame;
      end
      assign bit_out = word_q[idx_q];
   end else begin : g_shifting
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     word_q <= '0;
         else if (load)  word_q <= frame;
         else if (shift) word_q <= {word_q[TOTAL-2:0], 1'b0};
      end
      assign bit_out = word_q[TOTAL-1];
   end

   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !last);

endmodule

// File: rtl/led_chain_loader.sv
module led_chain_loader
   import ldr_pkg::*;
#(
   parameter int unsigned NUM_DEV     = 2,
   parameter int unsigned CH_PER_DEV  = 16,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYS_CLK_MHZ = 125,
   parameter int unsigned SHIFT_STYLE = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          frame_valid,
   output logic                          frame_ready,
   input  logic [NUM_DEV*CH_PER_DEV-1:0] frame_data,
   input  logic                          latch_bypass,
   input  logic [CNT_W-1:0]              cfg_half_cyc,
   input  logic [CNT_W-1:0]              cfg_setup_cyc,
   input  logic [CNT_W-1:0]              cfg_lew_cyc,
   input  logic [CNT_W-1:0]              cfg_gap_cyc,
   output logic                          drv_clk,
   output logic                          drv_sdi,
   output logic                          drv_le,
   output logic                          drv_blank,
   output logic                          load_done
);
   localparam int unsigned TOTAL     = NUM_DEV * CH_PER_DEV;
   localparam int unsigned FMAX_MHZ  = (NUM_DEV > 1) ? 25 : 30;
   localparam int unsigned PER_CYC   = cdiv(SYS_CLK_MHZ, FMAX_MHZ);
   localparam int unsigned MIN_HALF  = umax(cdiv(PER_CYC, 2), ns2cyc(16, SYS_CLK_MHZ));
   localparam int unsigned MIN_SETUP = ns2cyc(10, SYS_CLK_MHZ);
   localparam int unsigned MIN_HOLD  = ns2cyc(10, SYS_CLK_MHZ);
   localparam int unsigned MIN_LEW   = ns2cyc(20, SYS_CLK_MHZ);
   localparam int unsigned MIN_GAP   = ns2cyc(10, SYS_CLK_MHZ);
   localparam int unsigned MIN_OE    = ns2cyc(60, SYS_CLK_MHZ);
   localparam int unsigned NCFG      = 4;
   localparam int unsigned FLOORS [NCFG] = '{MIN_HALF, MIN_SETUP, MIN_LEW, MIN_GAP};

   // elaboration checks
   if (NUM_DEV < 1)                    begin : g_bad_ndev  $error("NUM_DEV must be at least 1"); end
   if (CH_PER_DEV < 2)                 begin : g_bad_ch    $error("CH_PER_DEV must be at least 2"); end
   if (SHIFT_STYLE > 1)                begin : g_bad_style $error("SHIFT_STYLE must be 0 or 1"); end
   if (MIN_HOLD > MIN_HALF)            begin : g_bad_hold  $error("hold floor exceeds high phase"); end
   if (TOTAL * 2 * MIN_HALF < MIN_OE)  begin : g_bad_oe    $error("blanking pulse below minimum"); end

   ldr_state_t state, state_n;

   logic             accept;
   logic             mode_q, byp_n;
   logic             tmr_start, tmr_exp;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_bit, sh_last, sh_shift;
   logic [CNT_W-1:0] raw_arr  [NCFG];
   logic [CNT_W-1:0] now_arr  [NCFG];
   logic [CNT_W-1:0] held_arr [NCFG];
   logic [CNT_W-1:0] lo_now, lo_held;
   logic             clk_q, le_q, blank_q, done_q;

   assign raw_arr[0] = cfg_half_cyc;
   assign raw_arr[1] = cfg_setup_cyc;
   assign raw_arr[2] = cfg_lew_cyc;
   assign raw_arr[3] = cfg_gap_cyc;

   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      ldr_floor #(.CW(CNT_W), .FLOOR(FLOORS[g])) u_floor (
         .clk     (clk),
         .rst_n   (rst_n),
         .capture (accept),
         .raw     (raw_arr[g]),
         .now     (now_arr[g]),
         .held    (held_arr[g])
      );
   end

   // low phase covers both the half-period and the data setup
   assign lo_now  = (now_arr[0]  > now_arr[1])  ? now_arr[0]  : now_arr[1];
   assign lo_held = (held_arr[0] > held_arr[1]) ? held_arr[0] : held_arr[1];

   assign frame_ready = (state == ST_IDLE);
   assign accept      = frame_ready && frame_valid;
   assign byp_n       = accept ? latch_bypass : mode_q;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE:     if (frame_valid) state_n = ST_SHIFT_LO;
         ST_SHIFT_LO: if (tmr_exp)     state_n = ST_SHIFT_HI;
         ST_SHIFT_HI: if (tmr_exp)     state_n = sh_last ? ST_LE_SETUP : ST_SHIFT_LO;
         ST_LE_SETUP: if (tmr_exp)     state_n = ST_LE_PULSE;
         ST_LE_PULSE: if (tmr_exp)     state_n = ST_LE_HOLD;
         ST_LE_HOLD:  if (tmr_exp)     state_n = ST_DONE;
         default:                      state_n = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_n)
         ST_SHIFT_LO: tmr_val = (state == ST_IDLE) ? lo_now : lo_held;
         ST_SHIFT_HI: tmr_val = held_arr[0];
         ST_LE_SETUP,
         ST_LE_HOLD:  tmr_val = held_arr[3];
         ST_LE_PULSE: tmr_val = held_arr[2];
         default:     tmr_val = CNT_W'(1);
      endcase
   end

   assign tmr_start = (state_n != state);
   assign sh_shift  = (state == ST_SHIFT_HI) && tmr_exp && !sh_last;

   ldr_timer #(.CW(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tmr_start),
      .start_val (tmr_val),
      .expired   (tmr_exp)
   );

   ldr_shifter #(.TOTAL(TOTAL), .STYLE(SHIFT_STYLE)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .frame   (frame_data),
      .shift   (sh_shift),
      .bit_out (sh_bit),
      .last    (sh_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         mode_q  <= 1'b0;
         clk_q   <= 1'b0;
         le_q    <= 1'b0;
         blank_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state   <= state_n;
         mode_q  <= byp_n;
         clk_q   <= (state_n == ST_SHIFT_HI);
         le_q    <= (state_n == ST_LE_PULSE) ||
                    (byp_n && (state_n inside {ST_SHIFT_LO, ST_SHIFT_HI, ST_LE_SETUP}));
         blank_q <= byp_n && (state_n != ST_IDLE);
         done_q  <= (state_n == ST_DONE);
      end
   end

   assign drv_clk   = clk_q;
   assign drv_le    = le_q;
   assign drv_blank = blank_q;
   assign load_done = done_q;
   assign drv_sdi   = (state inside {ST_SHIFT_LO, ST_SHIFT_HI}) ? sh_bit : 1'b0;

   assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ready |-> (!drv_clk && !drv_le && !load_done && !drv_blank));

   assert_sdi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_clk && $past(drv_clk)) |-> $stable(drv_sdi));

   assert_sdi_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_clk) |-> $stable(drv_sdi));

   assert_le_clk_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_le && !mode_q) |-> !drv_clk);

   assert_blank_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_clk && mode_q) |-> drv_blank);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> (!load_done && frame_ready));

endmodule

// File: tb/tb_led_chain_loader.sv
`timescale 1ns/1ps
module tb_led_chain_loader;
   localparam int NDEV = 2;
   localparam int TW   = NDEV * 16;
   localparam int PER  = 8;   // 125 MHz

   // floors from the device limits, computed from the clock period in ns
   localparam int PCYC = (40 + PER - 1) / PER;
   localparam int MH_A = (PCYC + 1) / 2;
   localparam int MH_B = (16 + PER - 1) / PER;
   localparam int MH   = (MH_A > MH_B) ? MH_A : MH_B;
   localparam int MS   = (10 + PER - 1) / PER;
   localparam int MW   = (20 + PER - 1) / PER;
   localparam int MG   = (10 + PER - 1) / PER;
   localparam int MOE  = (60 + PER - 1) / PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_valid = 1'b0;
   logic frame_ready;
   logic [TW-1:0] frame_data = '0;
   logic latch_bypass = 1'b0;
   logic [7:0] cfg_half_cyc = '0, cfg_setup_cyc = '0, cfg_lew_cyc = '0, cfg_gap_cyc = '0;
   logic drv_clk, drv_sdi, drv_le, drv_blank, load_done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #(PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   led_chain_loader #(.NUM_DEV(NDEV)) dut (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
      .frame_data(frame_data), .latch_bypass(latch_bypass),
      .cfg_half_cyc(cfg_half_cyc), .cfg_setup_cyc(cfg_setup_cyc),
      .cfg_lew_cyc(cfg_lew_cyc), .cfg_gap_cyc(cfg_gap_cyc),
      .drv_clk(drv_clk), .drv_sdi(drv_sdi), .drv_le(drv_le),
      .drv_blank(drv_blank), .load_done(load_done)
   );

   // behavioural device chain: 16-stage shift register plus level latches
   logic [15:0] sr  [NDEV];
   logic [15:0] lat [NDEV];
   initial for (int d = 0; d < NDEV; d++) begin sr[d] = '0; lat[d] = '0; end

   always @(posedge drv_clk) begin
      sr[0] <= {sr[0][14:0], drv_sdi};
      for (int d = 1; d < NDEV; d++) sr[d] <= {sr[d][14:0], sr[d-1][15]};
   end
   always @(negedge clk) if (drv_le) for (int d = 0; d < NDEV; d++) lat[d] <= sr[d];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] mk_frame(input int p);
      logic [TW-1:0] f;
      for (int i = 0; i < TW; i++) begin
         case (p)
            0:       f[i] = 1'b1;
            1:       f[i] = (i % 3 == 0);
            2:       f[i] = ((i * 7 + 3) >> 2) & 1;
            default: f[i] = (i == TW - 1);
         endcase
      end
      return f;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic run_load(input logic [TW-1:0] fr, input logic byp,
                           input int h, input int s, input int w, input int g);
      int H, L, W, G, K, c0, done_at, rises;
      int crun, lrun, brun, sf;
      int e_lo, e_hi, e_sdi, e_bit, e_lg, e_lw, e_bl, e_rdy;
      logic pclk, ple, pblank, sdi_r;
      H = mx(h, MH);
      L = mx(H, mx(s, MS));
      W = mx(w, MW);
      G = mx(g, MG);
      K = TW * (L + H) + 2 * G + W;
      e_lo = -1; e_hi = -1; e_sdi = -1; e_bit = -1; e_lg = -1; e_lw = -1; e_bl = -1; e_rdy = -1;
      crun = 0; lrun = 0; brun = 0; sf = 0; rises = 0; done_at = -1; sdi_r = 1'b0;
      pclk = 1'b0; ple = 1'b0; pblank = 1'b0;

      @(negedge clk); #1;
      chk(frame_ready == 1'b1, "R2 ready before offer", frame_ready, 1);
      frame_data = fr; latch_bypass = byp; frame_valid = 1'b1;
      cfg_half_cyc = 8'(h); cfg_setup_cyc = 8'(s); cfg_lew_cyc = 8'(w); cfg_gap_cyc = 8'(g);
      c0 = cyc;
      for (int t = 1; t <= K + 20 && done_at < 0; t++) begin
         @(negedge clk); #1;
         if (t == 1) begin frame_valid = 1'b0; cfg_half_cyc = 8'd1; cfg_lew_cyc = 8'd1; end
         if (t == 2) begin frame_valid = 1'b1; frame_data = ~fr; latch_bypass = ~byp; end
         if (t == 6) frame_valid = 1'b0;
         if (frame_ready && e_rdy < 0) e_rdy = t;
         if (drv_clk != pclk) begin
            if (drv_clk) begin
               if (crun != L && e_lo < 0) e_lo = crun;
               if (drv_sdi != fr[TW-1-rises] && e_bit < 0) e_bit = rises;
               sdi_r = drv_sdi;
               rises++;
            end else if (crun != H && e_hi < 0) e_hi = crun;
            crun = 1;
         end else crun++;
         if (drv_clk && drv_sdi != sdi_r && e_sdi < 0) e_sdi = t;
         if (pclk && !drv_clk) sf = 0; else sf++;
         if (drv_le != ple) begin
            if (drv_le && !byp && sf != G && e_lg < 0) e_lg = sf;
            if (!drv_le && lrun != (byp ? TW * (L + H) + G + W : W) && e_lw < 0) e_lw = lrun;
            lrun = 1;
         end else lrun++;
         if (drv_blank && !byp && e_bl < 0) e_bl = t;
         if (drv_blank != pblank) brun = 1; else brun++;
         pclk = drv_clk; ple = drv_le; pblank = drv_blank;
         if (load_done) done_at = cyc - c0;
      end
      chk(e_rdy < 0, "R2 ready low during load", e_rdy, -1);
      chk(e_lo < 0, "R5 low phase length", e_lo, L);
      chk(e_hi < 0, "R4 high phase length", e_hi, H);
      chk(e_sdi < 0, "R5 sdi stable while clock high", e_sdi, -1);
      chk(e_bit < 0, "R3 serial bit order", e_bit, -1);
      chk(rises == TW, "R3 rising edge count", rises, TW);
      chk(e_lw < 0, byp ? "R8 latch enable run" : "R6 latch enable width", e_lw,
          byp ? TW * (L + H) + G + W : W);
      chk(done_at == K + 1, "R7 done timing", done_at, K + 1);
      if (byp) begin
         chk(pblank && brun == K + 1 && brun >= MOE, "R8 blank run", brun, K + 1);
      end else begin
         chk(e_lg < 0, "R6 clock to latch spacing", e_lg, G);
         chk(e_bl < 0, "R9 blank stays low", e_bl, -1);
      end
      if (h < MH || w < MW || g < MG)
         chk(done_at == K + 1, "R10 floor clamp", done_at, K + 1);
      @(negedge clk); #1;
      chk(frame_ready && !load_done && !drv_blank, "R7 ready after done pulse",
          {frame_ready, load_done, drv_blank}, 3'b100);
      for (int d = 0; d < NDEV; d++)
         chk(lat[d] == fr[d*16 +: 16], "R3 R2 latched word", lat[d], fr[d*16 +: 16]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(frame_ready && !drv_clk && !drv_sdi && !drv_le && !drv_blank && !load_done,
          "R1 reset state", {frame_ready, drv_clk, drv_sdi, drv_le, drv_blank, load_done}, 6'b100000);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(frame_ready && !drv_clk && !drv_le && !load_done, "R1 idle after reset",
          {frame_ready, drv_clk, drv_le, load_done}, 4'b1000);
      for (int p = 0; p < 4; p++) begin
         run_load(mk_frame(p), 1'b0, 0, 0, 0, 0);
         run_load(mk_frame(p), 1'b0, 4, 1, 5, 3);
         run_load(mk_frame(p), 1'b1, 2, 6, 3, 4);
         run_load(mk_frame(p), 1'b1, 0, 0, 0, 0);
      end
      run_load(mk_frame(1), 1'b0, 5, 5, 4, 2);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule